// File: doc/BRIEF.md
# Read Bandwidth Request Throttler

This block paces the memory read requests of an image scaling engine. When the engine enlarges a picture it reads far less source data than it writes. Left unpaced, its reads can then flood the buffer of the shared bus. The block takes the four frame dimensions: source width and height, destination width and height. It works out how many times larger the destination area is than the source area, and turns that ratio into a pacing exponent N through a fixed sixteen-entry table. With N = 0 requests pass untouched. With N of one or more, only one read in every 4N cycles may complete.

The block sits on the read-request path as a valid/ready stage with no storage. It passes `up_valid` down as `dn_valid` and `dn_ready` up as `up_ready` only while its gate is open. A one-cycle configuration strobe loads new dimensions, and the exponent now in use can be read back at any time.

A three-state machine does the pacing. **FREE** is the state for N = 0, and the gate is always open there. **OPEN** is the state for N ≥ 1 while the block waits for a handshake, with the gate open. **HOLD** follows each handshake; the gate is shut there for 4N − 1 cycles. The transitions are: strobe with new N = 0 goes to FREE from any state; strobe with new N ≥ 1 goes to OPEN from any state; a handshake in OPEN goes to HOLD; the last hold cycle in HOLD goes to OPEN. A strobe takes priority over the other transitions.

Top module: `read_pace_throttle`

## Requirements
- R1: Reset is synchronous and active low. After reset, `pace_exp` reads 0, the machine is in FREE and the gate is open.
- R2: While N = 0, `up_ready` equals `dn_ready` and `dn_valid` equals `up_valid` in every cycle.
- R3: A strobe whose source area (width × height) is zero, or is not smaller than the destination area, selects N = 0.
- R4: In every other case, the index is floor(destination area / source area) − 1. N is the table entry at that index. The table holds, from index 0 to 15: 0,0,0,1,1,1,2,2,2,3,3,4,4,5,5,5.
- R5: An index above 15 (area ratio of 17 or more) saturates to 15, which gives N = 5.
- R6: With N ≥ 1, each completed handshake is followed by exactly 4N − 1 cycles in which `up_ready` and `dn_valid` are both low. The gate opens again in the cycle after that.
- R7: With N ≥ 1 and a request that stays valid while downstream stays ready, handshakes complete exactly 4N cycles apart.
- R8: A strobe ends any hold and resets the hold count. In the cycle after the strobe the gate is open under the new N. A handshake in the strobe cycle does not start a hold.
- R9: `pace_exp` (3-bit unsigned) changes only in the cycle after a strobe, and then shows the N selected by that strobe.
- R10: `dn_valid` is never high without `up_valid`. A hold starts only on a completed handshake (`up_valid` and `dn_ready` high while the gate is open). A stalled downstream keeps the gate open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load | input | 1 | One-cycle strobe that samples the four dimensions |
| cfg_src_w | input | DIM_W | Source frame width |
| cfg_src_h | input | DIM_W | Source frame height |
| cfg_dst_w | input | DIM_W | Destination frame width |
| cfg_dst_h | input | DIM_W | Destination frame height |
| up_valid | input | 1 | Read request valid from the scaling engine |
| up_ready | output | 1 | Read request accepted, toward the scaling engine |
| dn_valid | output | 1 | Read request valid toward memory |
| dn_ready | input | 1 | Memory side ready |
| pace_exp | output | 3 | Pacing exponent in use |

## Verification
The bound checker watches the cycle-level rules in every cycle: transparency at N = 0, the closed gate right after a handshake, the minimum 4N spacing between handshakes, the open gate after a strobe, `pace_exp` staying stable between strobes, and N = 0 for shrinking or empty sources. Only the bench scenarios can show that each area ratio maps to the right table entry and that large ratios saturate. They also show that the hold lasts exactly 4N − 1 cycles and no longer, that a stalled downstream does not start a hold, and that a reset taken in the middle of a hold brings back full rate.

// File: rtl/rrt_pkg.sv
package rrt_pkg;

    localparam int EXP_W     = 3;
    localparam int LUT_DEPTH = 16;
    localparam int IDX_W     = $clog2(LUT_DEPTH);

    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_OPEN = 2'd1,
        ST_HOLD = 2'd2
    } pace_state_t;

    // Hand-tuned ratio-to-exponent table; entry order is behaviour.
    function automatic logic [EXP_W-1:0] ratio_to_exp(input logic [IDX_W-1:0] idx);
        logic [EXP_W-1:0] e;
        unique case (idx)
            4'd0, 4'd1, 4'd2:    e = 3'd0;
            4'd3, 4'd4, 4'd5:    e = 3'd1;
            4'd6, 4'd7, 4'd8:    e = 3'd2;
            4'd9, 4'd10:         e = 3'd3;
            4'd11, 4'd12:        e = 3'd4;
            default:             e = 3'd5;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/rrt_area_ratio.sv
module rrt_area_ratio
    import rrt_pkg::*;
#(
    parameter int DIM_W = 12
) (
    input  logic [DIM_W-1:0] src_w,
    input  logic [DIM_W-1:0] src_h,
    input  logic [DIM_W-1:0] dst_w,
    input  logic [DIM_W-1:0] dst_h,
    output logic [IDX_W-1:0] ratio_idx,
    output logic             no_limit
);
    localparam int AREA_W = 2 * DIM_W;
    localparam int PROD_W = AREA_W + IDX_W + 1;
    localparam int NCMP   = LUT_DEPTH - 1;

    logic [AREA_W-1:0] src_area;
    logic [AREA_W-1:0] dst_area;
    logic [NCMP-1:0]   at_least;

    assign src_area = AREA_W'(src_w) * AREA_W'(src_h);
    assign dst_area = AREA_W'(dst_w) * AREA_W'(dst_h);

    // at_least[j] set when dst_area >= (j+2) * src_area; the count of set
    // bits is floor(dst/src) - 1, saturated at LUT_DEPTH - 1.
    for (genvar j = 0; j < NCMP; j++) begin : g_mult
        logic [PROD_W-1:0] scaled;
        assign scaled      = PROD_W'(src_area) * PROD_W'(j + 2);
        assign at_least[j] = PROD_W'(dst_area) >= scaled;
    end

    always_comb begin
        ratio_idx = '0;
        for (int j = 0; j < NCMP; j++) begin
            ratio_idx = ratio_idx + IDX_W'(at_least[j]);
        end
    end

    assign no_limit = (src_area == '0) || (src_area >= dst_area);

endmodule

// File: rtl/rrt_exp_lut.sv
module rrt_exp_lut
    import rrt_pkg::*;
(
    input  logic [IDX_W-1:0] ratio_idx,
    input  logic             no_limit,
    output logic [EXP_W-1:0] exp_sel
);
    always_comb begin
        if (no_limit) begin
            exp_sel = '0;
        end else begin
            exp_sel = ratio_to_exp(ratio_idx);
        end
    end
endmodule

// File: rtl/rrt_pacer.sv
module rrt_pacer
    import rrt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [EXP_W-1:0] new_exp,
    input  logic             up_valid,
    output logic             up_ready,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic [EXP_W-1:0] cur_exp
);
    localparam int CNT_W = EXP_W + 2;

    pace_state_t      state;
    pace_state_t      state_nxt;
    logic [CNT_W-1:0] hold_cnt;
    logic             gate_open;
    logic             fire;
    logic             hold_last;

    assign hold_last = (hold_cnt == ({cur_exp, 2'b00} - CNT_W'(2)));
    assign fire      = up_valid && dn_ready && gate_open;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FREE: state_nxt = ST_FREE;
            ST_OPEN: if (fire)      state_nxt = ST_HOLD;
            ST_HOLD: if (hold_last) state_nxt = ST_OPEN;
            default: state_nxt = ST_FREE;
        endcase
        if (cfg_load) begin
            state_nxt = (new_exp == '0) ? ST_FREE : ST_OPEN;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_FREE;
            hold_cnt <= '0;
            cur_exp  <= '0;
        end else begin
            state <= state_nxt;
            if (cfg_load || state != ST_HOLD) begin
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + CNT_W'(1);
            end
            if (cfg_load) begin
                cur_exp <= new_exp;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_FREE: gate_open = 1'b1;
            ST_OPEN: gate_open = 1'b1;
            ST_HOLD: gate_open = 1'b0;
            default: gate_open = 1'b1;
        endcase
        up_ready = dn_ready && gate_open;
        dn_valid = up_valid && gate_open;
    end

endmodule

// File: rtl/read_pace_throttle.sv
module read_pace_throttle
    import rrt_pkg::*;
#(
    parameter int DIM_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [DIM_W-1:0] cfg_src_w,
    input  logic [DIM_W-1:0] cfg_src_h,
    input  logic [DIM_W-1:0] cfg_dst_w,
    input  logic [DIM_W-1:0] cfg_dst_h,
    input  logic             up_valid,
    output logic             up_ready,
    output logic             dn_valid,
    input  logic             dn_ready,
    output logic [2:0]       pace_exp
);
    logic [IDX_W-1:0] ratio_idx;
    logic             no_limit;
    logic [EXP_W-1:0] exp_sel;
    logic [EXP_W-1:0] cur_exp;

    rrt_area_ratio #(.DIM_W(DIM_W)) u_ratio (
        .src_w     (cfg_src_w),
        .src_h     (cfg_src_h),
        .dst_w     (cfg_dst_w),
        .dst_h     (cfg_dst_h),
        .ratio_idx (ratio_idx),
        .no_limit  (no_limit)
    );

    rrt_exp_lut u_lut (
        .ratio_idx (ratio_idx),
        .no_limit  (no_limit),
        .exp_sel   (exp_sel)
    );

    rrt_pacer u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_load (cfg_load),
        .new_exp  (exp_sel),
        .up_valid (up_valid),
        .up_ready (up_ready),
        .dn_valid (dn_valid),
        .dn_ready (dn_ready),
        .cur_exp  (cur_exp)
    );

    assign pace_exp = cur_exp;

endmodule

// File: rtl/read_pace_throttle_chk.sv
module read_pace_throttle_chk #(
    parameter int DIM_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load,
    input logic [DIM_W-1:0] cfg_src_w,
    input logic [DIM_W-1:0] cfg_src_h,
    input logic [DIM_W-1:0] cfg_dst_w,
    input logic [DIM_W-1:0] cfg_dst_h,
    input logic             up_valid,
    input logic             up_ready,
    input logic             dn_valid,
    input logic             dn_ready,
    input logic [2:0]       pace_exp
);
    logic [2*DIM_W-1:0] a_src;
    logic [2*DIM_W-1:0] a_dst;
    logic               grant;
    logic [7:0]         gap;
    logic               seen;

    assign a_src = (2*DIM_W)'(cfg_src_w) * (2*DIM_W)'(cfg_src_h);
    assign a_dst = (2*DIM_W)'(cfg_dst_w) * (2*DIM_W)'(cfg_dst_h);
    assign grant = up_valid && up_ready;

    always_ff @(posedge clk) begin
        if (!rst_n || cfg_load) begin
            seen <= 1'b0;
            gap  <= '0;
        end else if (grant) begin
            seen <= 1'b1;
            gap  <= 8'd1;
        end else if (gap != 8'hFF) begin
            gap <= gap + 8'd1;
        end
    end

    // R2
    free_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pace_exp == 3'd0) |-> (up_ready == dn_ready && dn_valid == up_valid));

    // R10
    valid_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> up_valid);

    // R6
    hold_after_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && pace_exp != 3'd0 && !cfg_load) |=> (!up_ready && !dn_valid));

    // R7
    grant_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && seen && pace_exp != 3'd0) |-> (gap >= {3'b000, pace_exp, 2'b00}));

    // R8
    strobe_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (up_ready == dn_ready && dn_valid == up_valid));

    // R9
    exp_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load |=> $stable(pace_exp));

    // R3
    shrink_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && (a_src == '0 || a_src >= a_dst)) |=> (pace_exp == 3'd0));

endmodule

bind read_pace_throttle read_pace_throttle_chk #(.DIM_W(DIM_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .cfg_src_w (cfg_src_w),
    .cfg_src_h (cfg_src_h),
    .cfg_dst_w (cfg_dst_w),
    .cfg_dst_h (cfg_dst_h),
    .up_valid  (up_valid),
    .up_ready  (up_ready),
    .dn_valid  (dn_valid),
    .dn_ready  (dn_ready),
    .pace_exp  (pace_exp)
);

// File: tb/read_pace_throttle_tb.sv
module read_pace_throttle_tb;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_load;
    logic [DW-1:0] cfg_src_w, cfg_src_h, cfg_dst_w, cfg_dst_h;
    logic          up_valid, up_ready, dn_valid, dn_ready;
    logic [2:0]    pace_exp;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    read_pace_throttle #(.DIM_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load),
        .cfg_src_w(cfg_src_w), .cfg_src_h(cfg_src_h),
        .cfg_dst_w(cfg_dst_w), .cfg_dst_h(cfg_dst_h),
        .up_valid(up_valid), .up_ready(up_ready),
        .dn_valid(dn_valid), .dn_ready(dn_ready), .pace_exp(pace_exp)
    );

    // {src_w, src_h, dst_w, dst_h, expected exponent}
    localparam logic [4*DW+2:0] VEC [16] = '{
        {12'd100, 12'd100, 12'd100, 12'd100, 3'd0},  // R3 equal
        {12'd200, 12'd200, 12'd100, 12'd100, 3'd0},  // R3 shrink
        {12'd0,   12'd10,  12'd40,  12'd40,  3'd0},  // R3 empty source
        {12'd100, 12'd100, 12'd150, 12'd100, 3'd0},  // R4 idx0
        {12'd100, 12'd100, 12'd200, 12'd100, 3'd0},  // R4 idx1
        {12'd10,  12'd10,  12'd30,  12'd10,  3'd0},  // R4 idx2
        {12'd100, 12'd100, 12'd200, 12'd200, 3'd1},  // R4 idx3
        {12'd10,  12'd10,  12'd30,  12'd20,  3'd1},  // R4 idx5
        {12'd10,  12'd10,  12'd35,  12'd20,  3'd2},  // R4 idx6
        {12'd10,  12'd10,  12'd40,  12'd20,  3'd2},  // R4 idx7
        {12'd10,  12'd10,  12'd50,  12'd20,  3'd3},  // R4 idx9
        {12'd10,  12'd10,  12'd55,  12'd20,  3'd3},  // R4 idx10
        {12'd10,  12'd10,  12'd40,  12'd30,  3'd4},  // R4 idx11
        {12'd10,  12'd10,  12'd40,  12'd35,  3'd5},  // R4 idx13
        {12'd10,  12'd10,  12'd40,  12'd40,  3'd5},  // R4 idx15
        {12'd10,  12'd10,  12'd100, 12'd100, 3'd5}   // R5 saturate
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Drive at negedge, strobe for one cycle, return 1 ns after next negedge.
    task automatic load_cfg(input int sw, input int sh, input int dw_, input int dh);
        @(negedge clk);
        cfg_src_w = DW'(sw); cfg_src_h = DW'(sh);
        cfg_dst_w = DW'(dw_); cfg_dst_h = DW'(dh);
        cfg_load  = 1'b1;
        @(negedge clk);
        cfg_load  = 1'b0;
        #1;
    endtask

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    // Continuous request: grants must be exactly 4n apart (R7), gate low between (R6).
    task automatic measure(input int n, input int cycles);
        int last = -1;
        int ng   = 0;
        for (int c = 0; c < cycles; c++) begin
            if (up_ready && up_valid) begin
                if (last >= 0) chk(c - last == 4*n, "R7 grant spacing", c - last, 4*n);
                last = c;
                ng++;
            end else begin
                chk(!dn_valid, "R6 dn_valid low in hold", int'(dn_valid), 0);
            end
            tick();
        end
        chk(ng == (cycles + 4*n - 1) / (4*n), "R7 grant count", ng, (cycles + 4*n - 1) / (4*n));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_load = 1'b0;
        cfg_src_w = '0; cfg_src_h = '0; cfg_dst_w = '0; cfg_dst_h = '0;
        up_valid = 1'b1; dn_ready = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk(pace_exp == 3'd0, "R1 reset exponent", pace_exp, 0);
        chk(up_ready && dn_valid, "R1 gate open after reset", int'(up_ready), 1);

        // R2 transparency at N=0
        for (int i = 0; i < 4; i++) begin
            up_valid = i[0]; dn_ready = i[1];
            #1;
            chk(up_ready == dn_ready && dn_valid == up_valid, "R2 pass-through",
                {up_ready, dn_valid}, {dn_ready, up_valid});
            tick();
        end

        // Table walk: R3 R4 R5 R9
        up_valid = 1'b0; dn_ready = 1'b1;
        for (int v = 0; v < 16; v++) begin
            load_cfg(int'(VEC[v][4*DW+2 -: DW]), int'(VEC[v][3*DW+2 -: DW]),
                     int'(VEC[v][2*DW+2 -: DW]), int'(VEC[v][DW+2 -: DW]));
            chk(pace_exp == VEC[v][2:0], "R4 R9 exponent lookup", pace_exp, int'(VEC[v][2:0]));
        end

        // R7 R6 spacing for N=1 and N=2
        up_valid = 1'b1; dn_ready = 1'b1;
        load_cfg(10, 10, 20, 20);
        chk(pace_exp == 3'd1, "R4 N=1 config", pace_exp, 1);
        measure(1, 40);
        load_cfg(10, 10, 40, 20);
        chk(pace_exp == 3'd2, "R4 N=2 config", pace_exp, 2);
        measure(2, 48);
        chk(pace_exp == 3'd2, "R9 exponent stable without strobe", pace_exp, 2);

        // R6 single request, N=2: 7 closed cycles then open
        up_valid = 1'b0;
        load_cfg(10, 10, 40, 20);
        up_valid = 1'b1; #1;
        chk(up_ready, "R6 first grant", int'(up_ready), 1);
        tick();
        up_valid = 1'b0;
        for (int i = 0; i < 7; i++) begin
            chk(!up_ready, "R6 closed after grant", int'(up_ready), 0);
            tick();
        end
        chk(up_ready, "R6 reopens after 4N-1", int'(up_ready), 1);

        // R10 stalled downstream keeps gate open, no hold
        up_valid = 1'b1; dn_ready = 1'b0; #1;
        for (int i = 0; i < 3; i++) begin
            chk(dn_valid && !up_ready, "R10 stall keeps gate open", int'(dn_valid), 1);
            tick();
        end
        dn_ready = 1'b1; #1;
        chk(up_ready, "R10 grant after stall", int'(up_ready), 1);
        tick();
        chk(!up_ready && !dn_valid, "R10 hold after completed handshake", int'(dn_valid), 0);
        up_valid = 1'b0; #1;
        chk(!dn_valid, "R10 no valid without request", int'(dn_valid), 0);
        up_valid = 1'b1;

        // R8 strobe aborts hold under N=5
        load_cfg(10, 10, 40, 40);
        chk(up_ready, "R8 open after strobe", int'(up_ready), 1);
        tick();
        tick();
        chk(!up_ready, "R8 in hold before strobe", int'(up_ready), 0);
        load_cfg(10, 10, 20, 20);
        chk(up_ready && pace_exp == 3'd1, "R8 strobe reopens gate", int'(up_ready), 1);
        chk(pace_exp == 3'd1, "R9 new exponent visible", pace_exp, 1);

        // R1 reset mid-hold
        tick();
        chk(!up_ready, "R6 hold before reset", int'(up_ready), 0);
        @(negedge clk); rst_n = 1'b0;
        tick();
        rst_n = 1'b1; #1;
        chk(pace_exp == 3'd0 && up_ready, "R1 reset clears hold", pace_exp, 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule